// File: doc/BRIEF.md
# Programmable Convolutional Byte De-interleaver

This block undoes the convolutional byte interleaving applied to a transport stream before transmission. Each accepted byte is handed to one of `D` branches in turn, one byte per branch, and each branch is a first-in first-out delay line of its own length. The branch lengths form a staircase, so that the interleaver on the transmit side and this block together give every byte the same total delay. Branch 0 has the longest delay and the last branch has none. The branch selector is locked to packet framing: the byte marked as a packet start always goes to branch 0.

The branch count `D`, the step `I` between neighbouring branch lengths and the packet length `N` can all be set while the system is running, through a small register write port. The setting with 12 branches and a packet length of 204 is the deepest one supported. Every branch lives in one shared byte memory, carved into regions whose start addresses are worked out from the written values. A new setting is held back until the next packet start. At that packet start the block restarts: every branch pointer is cleared and the output is marked invalid until the longest branch has filled again. After reset, the block ignores all bytes until it sees its first packet start.

Top module: `conv_deinterleaver`

## Requirements
- R1: During and straight after reset, `out_valid` and `out_sof` are low.
- R2: Bytes that arrive before the first packet start (`in_valid` and `in_sof` high together) are ignored. Counting the restarting packet-start byte as index 0, the first byte whose output has `out_valid` high is the one with index (D-1)*I*D.
- R3: Accepted bytes go to branches 0,1,…,D-1 cyclically. A byte with `in_sof` high always goes to branch 0. Branch b returns, on `out_byte`, the byte it received (D-1-b)*I of its own visits earlier. The result appears in the cycle after the byte is accepted.
- R4: `out_valid` is high only in the cycle after an accepted byte, and only once the block has filled as set out in R2.
- R5: A register write (`cfg_sel` 0 = branch count 1..DMAX, 1 = step 1..INC_MAX, 2 = packet length ≥ 1) has no effect on the output until the next packet start. Until then the previous setting keeps running and `out_valid` stays high.
- R6: A packet start that follows a legal write restarts the block. `out_valid` then drops and comes back only after (D-1)*I*D further bytes, counted with the new values.
- R7: A write of a value outside its range is ignored. It does not cause a restart at the next packet start.
- R8: `out_sof` is high with the first valid output after a restart, and again on every N-th valid output after that.
- R9: With D=1 the block passes bytes straight through, one cycle later, and its output is valid from the restarting byte onward.
- R10: A cycle with `in_valid` low produces no valid output in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input byte strobe |
| in_byte | input | 8 | Input byte |
| in_sof | input | 1 | Marks the first byte of a packet |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 branch count, 1 step, 2 packet length |
| cfg_wdata | input | WD_W | Register write value |
| out_valid | output | 1 | Output byte is valid (the block has filled) |
| out_byte | output | 8 | De-interleaved byte |
| out_sof | output | 1 | First byte of an output packet |

## Verification
The hardest situation to reach from the ports is a setting change in the middle of a running stream. It has to be shown that the old staircase keeps producing correct, valid bytes after the write and right up to the packet boundary. After that boundary, the refill has to restart from zero with the new geometry. The bench first runs the deepest setting until it is full. It then writes the new values partway through a packet, streams to the end of that packet, and checks how many valid outputs appear before and after the boundary. A per-branch reference queue predicts every byte. The same queue also covers a packet start forced early and input with gaps.

// File: rtl/dlv_pkg.sv
// Package: shared types and arithmetic for the convolutional de-interleaver.
// Assumes: callers pass a branch index below the branch count.
package dlv_pkg;

    // Register select codes on the write port
    typedef enum logic [1:0] {
        CFG_DEPTH = 2'd0,
        CFG_INC   = 2'd1,
        CFG_BLEN  = 2'd2
    } cfg_sel_e;

    // First memory address of branch j: the sum of the lengths of branches 0..j-1
    function automatic int branch_base(input int depth, input int inc, input int j);
        return inc * (j * (depth - 1) - (j * (j - 1)) / 2);
    endfunction

endpackage

// File: rtl/dlv_cfg.sv
// Module: dlv_cfg
// Holds the shadow registers written by the host and the active setting used by
// the datapath. Computes branch base addresses and lengths from the shadow values.
// The shadow values are copied into the active set when `load` fires.
// Assumes: `load` comes from the pointer unit at a restarting packet start.
// The eff_* outputs show the setting that applies to the byte in the current
// cycle, which is the new one on a load cycle.
module dlv_cfg #(
    parameter int DMAX      = 12,
    parameter int INC_MAX   = 17,
    parameter int WD_W      = 8,
    parameter int BW        = 4,
    parameter int IW        = 5,
    parameter int AW        = 11,
    parameter int LW        = 8,
    parameter int CW        = 12,
    parameter int DEF_DEPTH = 12,
    parameter int DEF_INC   = 17,
    parameter int DEF_BLEN  = 204
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [1:0]      cfg_sel,
    input  logic [WD_W-1:0] cfg_wdata,
    input  logic            load,
    output logic            pend,
    output logic [BW-1:0]   eff_depth,
    output logic [AW-1:0]   eff_base [DMAX],
    output logic [LW-1:0]   eff_len  [DMAX],
    output logic [CW-1:0]   eff_maxdly,
    output logic [WD_W-1:0] act_blen
);
    import dlv_pkg::*;

    logic [BW-1:0]   sh_depth;
    logic [IW-1:0]   sh_inc;
    logic [WD_W-1:0] sh_blen;
    logic            legal;
    int              wd;

    logic [BW-1:0]   act_depth;
    logic [AW-1:0]   act_base [DMAX];
    logic [LW-1:0]   act_len  [DMAX];
    logic [CW-1:0]   act_maxdly;

    logic [AW-1:0]   new_base [DMAX];
    logic [LW-1:0]   new_len  [DMAX];
    logic [CW-1:0]   new_maxdly;

    // Range check of the value being written
    always_comb begin
        wd = int'(cfg_wdata);
        case (cfg_sel)
            CFG_DEPTH: legal = (wd >= 1) && (wd <= DMAX);
            CFG_INC:   legal = (wd >= 1) && (wd <= INC_MAX);
            CFG_BLEN:  legal = (wd >= 1);
            default:   legal = 1'b0;
        endcase
    end

    // Shadow registers and the pending flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_depth <= BW'(DEF_DEPTH);
            sh_inc   <= IW'(DEF_INC);
            sh_blen  <= WD_W'(DEF_BLEN);
            pend     <= 1'b0;
        end else begin
            if (load) pend <= 1'b0;
            if (cfg_we && legal) begin
                case (cfg_sel)
                    CFG_DEPTH: sh_depth <= BW'(cfg_wdata);
                    CFG_INC:   sh_inc   <= IW'(cfg_wdata);
                    default:   sh_blen  <= cfg_wdata;
                endcase
                pend <= 1'b1;
            end
        end
    end

    // Branch geometry derived from the shadow values
    always_comb begin
        for (int j = 0; j < DMAX; j++) begin
            if (j < int'(sh_depth)) begin
                new_len[j]  = LW'((int'(sh_depth) - 1 - j) * int'(sh_inc));
                new_base[j] = AW'(branch_base(int'(sh_depth), int'(sh_inc), j));
            end else begin
                new_len[j]  = '0;
                new_base[j] = '0;
            end
        end
        new_maxdly = CW'((int'(sh_depth) - 1) * int'(sh_inc) * int'(sh_depth));
    end

    // Active setting, replaced at a restart
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_depth  <= BW'(1);
            act_maxdly <= '0;
            act_blen   <= WD_W'(1);
            for (int j = 0; j < DMAX; j++) begin
                act_base[j] <= '0;
                act_len[j]  <= '0;
            end
        end else if (load) begin
            act_depth  <= sh_depth;
            act_maxdly <= new_maxdly;
            act_blen   <= sh_blen;
            for (int j = 0; j < DMAX; j++) begin
                act_base[j] <= new_base[j];
                act_len[j]  <= new_len[j];
            end
        end
    end

    // Setting in force for the byte of this cycle
    always_comb begin
        eff_depth  = load ? sh_depth : act_depth;
        eff_maxdly = load ? new_maxdly : act_maxdly;
        for (int j = 0; j < DMAX; j++) begin
            eff_base[j] = load ? new_base[j] : act_base[j];
            eff_len[j]  = load ? new_len[j]  : act_len[j];
        end
    end

    // R5: the active setting only moves on a restart
    a_r5_hold_until_sof: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(act_depth) && $stable(act_maxdly) && $stable(act_blen));

    // R7: the pending flag rises only after a write strobe
    a_r7_pend_from_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend) |-> $past(cfg_we));

endmodule

// File: rtl/dlv_ptr.sv
// Module: dlv_ptr
// Branch selector, per-branch pointers and fill counter. Turns each accepted
// byte into one read-before-write access of the shared memory, or marks it as
// bypass when its branch has length zero.
// Assumes: the eff_* inputs already show the new setting on a load cycle.
module dlv_ptr #(
    parameter int DMAX      = 12,
    parameter int BW        = 4,
    parameter int AW        = 11,
    parameter int LW        = 8,
    parameter int CW        = 12,
    parameter int MEM_WORDS = 1122
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_sof,
    input  logic          pend,
    input  logic [BW-1:0] eff_depth,
    input  logic [AW-1:0] eff_base [DMAX],
    input  logic [LW-1:0] eff_len  [DMAX],
    input  logic [CW-1:0] eff_maxdly,
    output logic          load,
    output logic          accept,
    output logic          ram_we,
    output logic [AW-1:0] ram_addr,
    output logic          bypass,
    output logic          fill_ok
);
    logic          running;
    logic [BW-1:0] comm;
    logic [BW-1:0] branch;
    logic [BW-1:0] comm_nx;
    logic [LW-1:0] ptr [DMAX];
    logic [LW-1:0] cur_len;
    logic [LW-1:0] cur_ptr;
    logic [LW-1:0] ptr_nx;
    logic [CW-1:0] fill_cnt;
    logic [CW-1:0] cnt_b;

    // Decode this cycle's byte: restart, branch, address, fill state
    always_comb begin
        load     = in_valid && in_sof && (!running || pend);
        accept   = in_valid && (running || in_sof);
        branch   = in_sof ? '0 : comm;
        cur_len  = eff_len[branch];
        cur_ptr  = load ? '0 : ptr[branch];
        bypass   = (cur_len == '0);
        ram_addr = eff_base[branch] + AW'(cur_ptr);
        ram_we   = accept && !bypass;
        ptr_nx   = (LW'(cur_ptr + 1'b1) == cur_len) ? '0 : LW'(cur_ptr + 1'b1);
        comm_nx  = (BW'(branch + 1'b1) == eff_depth) ? '0 : BW'(branch + 1'b1);
        cnt_b    = load ? '0 : fill_cnt;
        fill_ok  = (cnt_b >= eff_maxdly);
    end

    // Advance the selector, pointers and fill counter on each accepted byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running  <= 1'b0;
            comm     <= '0;
            fill_cnt <= '0;
            for (int j = 0; j < DMAX; j++) ptr[j] <= '0;
        end else if (accept) begin
            if (load) running <= 1'b1;
            comm     <= comm_nx;
            fill_cnt <= fill_ok ? cnt_b : CW'(cnt_b + 1'b1);
            if (load) begin
                for (int j = 0; j < DMAX; j++) ptr[j] <= '0;
            end
            if (!bypass) ptr[branch] <= ptr_nx;
        end
    end

    // R3: the selector stays within the active branch count
    a_r3_comm_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !load) |-> (comm < eff_depth));

    // R3: every memory access falls inside the shared memory
    a_r3_addr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (int'(ram_addr) < MEM_WORDS));

endmodule

// File: rtl/dlv_ram.sv
// Module: dlv_ram
// Single-port byte memory with read-before-write. The registered read port
// returns the old contents of the addressed word, one cycle later.
// Assumes: contents are undefined until written; no reset on the array.
module dlv_ram #(
    parameter int WORDS = 1122,
    parameter int AW    = 11
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);
    logic [7:0] mem [WORDS];

    // Read the old word and write the new one in the same cycle
    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
        rdata <= mem[addr];
    end

endmodule

// File: rtl/conv_deinterleaver.sv
// Module: conv_deinterleaver (top)
// Convolutional byte de-interleaver whose branch count, branch step and packet
// length can be changed at run time. Links the register unit, the pointer unit
// and the shared memory. Adds the output stage and the output packet marker.
// Assumes: upstream framing supplies in_sof on the first byte of each packet.
module conv_deinterleaver #(
    parameter int DMAX      = 12,
    parameter int INC_MAX   = 17,
    parameter int WD_W      = 8,
    parameter int DEF_DEPTH = 12,
    parameter int DEF_INC   = 17,
    parameter int DEF_BLEN  = 204
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [7:0]      in_byte,
    input  logic            in_sof,
    input  logic            cfg_we,
    input  logic [1:0]      cfg_sel,
    input  logic [WD_W-1:0] cfg_wdata,
    output logic            out_valid,
    output logic [7:0]      out_byte,
    output logic            out_sof
);
    localparam int MEM_RAW   = INC_MAX * DMAX * (DMAX - 1) / 2;
    localparam int MEM_WORDS = (MEM_RAW > 2) ? MEM_RAW : 2;
    localparam int AW        = $clog2(MEM_WORDS);
    localparam int BW        = $clog2(DMAX + 1);
    localparam int IW        = $clog2(INC_MAX + 1);
    localparam int LW        = $clog2(DMAX * INC_MAX + 1);
    localparam int CW        = $clog2(DMAX * DMAX * INC_MAX + 1);

    logic            pend;
    logic            load;
    logic            accept;
    logic            ram_we;
    logic            bypass;
    logic            fill_ok;
    logic [AW-1:0]   ram_addr;
    logic [7:0]      ram_q;
    logic [BW-1:0]   eff_depth;
    logic [AW-1:0]   eff_base [DMAX];
    logic [LW-1:0]   eff_len  [DMAX];
    logic [CW-1:0]   eff_maxdly;
    logic [WD_W-1:0] act_blen;

    logic            st_valid;
    logic            st_ok;
    logic            st_bypass;
    logic [7:0]      st_byte;
    logic [WD_W-1:0] ocnt;

    dlv_cfg #(
        .DMAX(DMAX), .INC_MAX(INC_MAX), .WD_W(WD_W), .BW(BW), .IW(IW),
        .AW(AW), .LW(LW), .CW(CW), .DEF_DEPTH(DEF_DEPTH), .DEF_INC(DEF_INC),
        .DEF_BLEN(DEF_BLEN)
    ) cfg_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .load(load), .pend(pend), .eff_depth(eff_depth),
        .eff_base(eff_base), .eff_len(eff_len), .eff_maxdly(eff_maxdly),
        .act_blen(act_blen)
    );

    dlv_ptr #(
        .DMAX(DMAX), .BW(BW), .AW(AW), .LW(LW), .CW(CW), .MEM_WORDS(MEM_WORDS)
    ) ptr_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
        .pend(pend), .eff_depth(eff_depth), .eff_base(eff_base),
        .eff_len(eff_len), .eff_maxdly(eff_maxdly), .load(load),
        .accept(accept), .ram_we(ram_we), .ram_addr(ram_addr),
        .bypass(bypass), .fill_ok(fill_ok)
    );

    dlv_ram #(.WORDS(MEM_WORDS), .AW(AW)) ram_i (
        .clk(clk), .we(ram_we), .addr(ram_addr), .wdata(in_byte), .rdata(ram_q)
    );

    // Output stage, aligned with the memory read latency
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_valid  <= 1'b0;
            st_ok     <= 1'b0;
            st_bypass <= 1'b0;
            st_byte   <= '0;
        end else begin
            st_valid  <= accept;
            st_ok     <= fill_ok;
            st_bypass <= bypass;
            st_byte   <= in_byte;
        end
    end

    assign out_valid = st_valid && st_ok;
    assign out_byte  = st_bypass ? st_byte : ram_q;

    // Position of the valid output within its packet, cleared at a restart
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            ocnt <= '0;
        end else if (out_valid) begin
            ocnt <= (WD_W'(ocnt + 1'b1) == act_blen) ? '0 : WD_W'(ocnt + 1'b1);
        end
    end

    assign out_sof = out_valid && (ocnt == '0);

    // R10: an idle input cycle yields no valid output
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R4: a valid output always follows an input strobe
    a_r4_valid_after_input: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));

endmodule

// File: tb/conv_deinterleaver_tb_top.sv
`timescale 1ns/1ps
module conv_deinterleaver_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       in_valid;
    logic [7:0] in_byte;
    logic       in_sof;
    logic       cfg_we;
    logic [1:0] cfg_sel;
    logic [7:0] cfg_wdata;
    logic       out_valid;
    logic [7:0] out_byte;
    logic       out_sof;

    always #2.5 clk = ~clk;

    conv_deinterleaver dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .in_sof(in_sof), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .out_valid(out_valid), .out_byte(out_byte),
        .out_sof(out_sof)
    );

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    // Reference model state, built from the requirements
    int m_run = 0, m_pend = 0;
    int sD = 12, sI = 17, sN = 204;
    int aD = 1, aI = 1, aN = 1, maxd = 0;
    int comm = 0, fill = 0, ocnt = 0;
    int vis [12];
    logic [7:0] hist [12][4096];
    bit exp_have = 0, exp_valid = 0, exp_sof = 0, exp_known = 0;
    logic [7:0] exp_byte;
    int prev_idx = -1, first_valid_at = -1;
    int valid_obs = 0, idle_leak = 0;
    bit last_v = 0;
    int dcount = 0, fpos = 0, curN = 204;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // One clock: sample the previous result, update the model, drive inputs
    task automatic cycle(input bit v, input logic [7:0] b, input bit s,
                         input bit we, input logic [1:0] sel, input logic [7:0] wd);
        int br, len;
        @(negedge clk);
        if (exp_have) begin
            check(out_valid == exp_valid, "R4", "out_valid", out_valid, exp_valid);
            if (exp_valid) begin
                if (exp_known)
                    check(out_byte == exp_byte, "R3", "out_byte", out_byte, exp_byte);
                check(out_sof == exp_sof, "R8", "out_sof", out_sof, exp_sof);
            end
        end
        if (out_valid) valid_obs++;
        if (out_valid && !last_v) idle_leak++;
        if (out_valid && first_valid_at < 0) first_valid_at = prev_idx;
        if (we) begin
            if (sel == 2'd0 && wd >= 1 && wd <= 12) begin sD = int'(wd); m_pend = 1; end
            if (sel == 2'd1 && wd >= 1 && wd <= 17) begin sI = int'(wd); m_pend = 1; end
            if (sel == 2'd2 && wd >= 1) begin sN = int'(wd); m_pend = 1; end
        end
        exp_have = 1; exp_valid = 0; exp_sof = 0; exp_known = 0; prev_idx = -1;
        if (v && s && (m_run == 0 || m_pend != 0)) begin
            aD = sD; aI = sI; aN = sN; maxd = (aD - 1) * aI * aD;
            for (int j = 0; j < 12; j++) vis[j] = 0;
            fill = 0; ocnt = 0; comm = 0; m_run = 1; m_pend = 0; first_valid_at = -1;
        end
        if (v && m_run != 0) begin
            br  = s ? 0 : comm;
            len = (aD - 1 - br) * aI;
            if (len == 0) begin exp_byte = b; exp_known = 1; end
            else if (vis[br] >= len) begin exp_byte = hist[br][vis[br] - len]; exp_known = 1; end
            if (vis[br] < 4096) hist[br][vis[br]] = b;
            vis[br]++;
            comm = (br + 1) % aD;
            prev_idx = fill;
            exp_valid = (fill >= maxd);
            fill++;
            if (exp_valid) begin
                exp_sof = (ocnt == 0);
                ocnt = (ocnt + 1) % aN;
            end
        end
        last_v = v;
        in_valid = v; in_byte = b; in_sof = s;
        cfg_we = we; cfg_sel = sel; cfg_wdata = wd;
    endtask

    task automatic feed(input int n);
        for (int k = 0; k < n; k++) begin
            cycle(1'b1, 8'((dcount * 37 + 11) & 255), (fpos % curN) == 0, 1'b0, 2'd0, 8'd0);
            dcount++; fpos++;
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] wd);
        cycle(1'b0, 8'd0, 1'b0, 1'b1, sel, wd);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; in_valid = 0; in_byte = 0; in_sof = 0;
        cfg_we = 0; cfg_sel = 0; cfg_wdata = 0;
        repeat (4) @(negedge clk);
        check(out_valid == 1'b0 && out_sof == 1'b0, "R1", "outputs in reset", out_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0 && out_sof == 1'b0, "R1", "outputs after reset", out_valid, 0);
    endtask

    task automatic t_pre_sync();
        valid_obs = 0;
        for (int k = 0; k < 25; k++) cycle(1'b1, 8'(k), 1'b0, 1'b0, 2'd0, 8'd0);
        cycle(1'b0, 8'd0, 1'b0, 1'b0, 2'd0, 8'd0);
        check(valid_obs == 0, "R2", "valid before first packet start", valid_obs, 0);
    endtask

    task automatic t_default();
        fpos = 0; curN = 204;
        feed(204 * 14);
        check(first_valid_at == 2244, "R2", "first valid byte index (12,17)", first_valid_at, 2244);
    endtask

    task automatic t_runtime_cfg();
        feed(30);
        wr(2'd0, 8'd3); wr(2'd1, 8'd2); wr(2'd2, 8'd6);
        valid_obs = 0;
        feed(20);
        cycle(1'b0, 8'd0, 1'b0, 1'b0, 2'd0, 8'd0);
        check(valid_obs == 20, "R5", "old setting keeps running", valid_obs, 20);
        feed(204 - (fpos % 204));
        fpos = 0; curN = 6;
        feed(120);
        check(first_valid_at == 12, "R6", "refill after restart (3,2)", first_valid_at, 12);
    endtask

    task automatic t_illegal();
        wr(2'd0, 8'd0); wr(2'd0, 8'd13); wr(2'd1, 8'd0); wr(2'd1, 8'd18); wr(2'd2, 8'd0);
        valid_obs = 0;
        feed(12);
        cycle(1'b0, 8'd0, 1'b0, 1'b0, 2'd0, 8'd0);
        check(valid_obs == 12, "R7", "no restart after illegal writes", valid_obs, 12);
        check(first_valid_at == 12, "R7", "fill point unchanged", first_valid_at, 12);
    endtask

    task automatic t_depth1();
        wr(2'd0, 8'd1); wr(2'd1, 8'd5); wr(2'd2, 8'd5);
        fpos = 0; curN = 5;
        feed(20);
        check(first_valid_at == 0, "R9", "pass-through valid at once", first_valid_at, 0);
    endtask

    task automatic t_gaps_realign();
        int e0;
        wr(2'd0, 8'd4); wr(2'd1, 8'd1); wr(2'd2, 8'd8);
        fpos = 0; curN = 8; idle_leak = 0;
        for (int k = 0; k < 80; k++) begin
            feed(1);
            cycle(1'b0, 8'd0, 1'b0, 1'b0, 2'd0, 8'd0);
        end
        cycle(1'b0, 8'd0, 1'b0, 1'b0, 2'd0, 8'd0);
        check(idle_leak == 0, "R10", "valid after idle input", idle_leak, 0);
        check(first_valid_at == 12, "R2", "first valid index (4,1)", first_valid_at, 12);
        e0 = errors;
        feed(5);
        fpos = 0;
        feed(40);
        cycle(1'b0, 8'd0, 1'b0, 1'b0, 2'd0, 8'd0);
        check(errors == e0, "R3", "early packet start forces branch 0", errors - e0, 0);
    endtask

    initial begin
        t_reset();
        t_pre_sync();
        t_default();
        t_runtime_cfg();
        t_illegal();
        t_depth1();
        t_gaps_realign();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule